// File: doc/BRIEF.md
# Replicating Four-Column Write Bank

This block is a small byte store built from four independent columns. Each column keeps its own words and has its own read port with its own address, so four different bytes can be fetched in one cycle. There is only one write port. Each write carries a 2-bit pattern code, and that code selects which columns take the byte at the shared write address.

Issuing writes to one address with different pattern codes on successive cycles leaves chosen values in chosen columns. Issuing one write with the all-columns code copies a byte into every column. A datapath can use this to fan operands out to several consumers, as if the store had several true read ports. Reads are registered, so data appears one cycle after the address is presented. A reset clears every stored byte and every read output.

Top module: `rcb_bank`

## Requirements
- R1: While `rst_n` is low at a rising edge, every stored byte and all four read lanes become zero.
- R2: A write with pattern code 2'b00 stores the byte into all four columns, which are read lanes 0 to 3.
- R3: A write with pattern code 2'b01 stores the byte into columns 1 and 2 (lanes 0 and 1) only. Columns 3 and 4 keep their contents.
- R4: A write with pattern code 2'b10 stores the byte into columns 1 and 3 (lanes 0 and 2) only. Columns 2 and 4 keep their contents.
- R5: A write with pattern code 2'b11 stores the byte into column 1 (lane 0) only.
- R6: While `wr_en` is low, no column changes, whatever the pattern code, address and data are.
- R7: Read lane k returns, one cycle after the edge, the byte that column k+1 held at the address taken from bits [4k+3:4k] of `rd_addr`. Lane k occupies bits [8k+7:8k] of `rd_data`. The lane holds steady while its address stays the same and no write occurs.
- R8: The four lanes can be read at four different addresses in the same cycle.
- R9: A read and a write to the same column and address at the same edge returns the old byte. The new byte is visible one edge later.
- R10: Each pattern code applies for a single clock. Four writes to one address with codes 00, 01, 10 and 11 in that order therefore leave the last byte in column 1, the 01 byte in column 2, the 10 byte in column 3 and the 00 byte in column 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_pat | input | 2 | Column pattern code for this write |
| wr_addr | input | 4 | Write address, shared by all columns |
| wr_data | input | 8 | Byte to store |
| rd_addr | input | 16 | Four packed 4-bit read addresses, lane k at [4k+3:4k] |
| rd_data | output | 32 | Four packed registered read bytes, lane k at [8k+7:8k] |

## Verification
The bench builds the block with the default 8-bit words and 4-bit addresses, which gives 16 entries per column. At this depth a short random run writes and reads every address of every column many times, under all four pattern codes. The same-cycle read-over-write collision and the address wrap at entry 15 both come up often. The small depth also makes it cheap to confirm that a reset in the middle of a run clears all 64 bytes.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  localparam int unsigned NUM_COL = 4;

  typedef enum logic [1:0] {
    PAT_ALL = 2'b00,
    PAT_C12 = 2'b01,
    PAT_C13 = 2'b10,
    PAT_C1  = 2'b11
  } pat_e;

  // Column enable mask, bit i selects column i+1.
  function automatic logic [NUM_COL-1:0] pat_mask(input pat_e p);
    logic [NUM_COL-1:0] m;
    case (p)
      PAT_ALL: m = 4'b1111;
      PAT_C12: m = 4'b0011;
      PAT_C13: m = 4'b0101;
      default: m = 4'b0001;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/rcb_pat_dec.sv
module rcb_pat_dec
  import rcb_pkg::*;
(
  input  logic               wr_en,
  input  logic [1:0]         wr_pat,
  output logic [NUM_COL-1:0] col_we
);
  always_comb begin
    col_we = wr_en ? pat_mask(pat_e'(wr_pat)) : '0;
  end
endmodule

// File: rtl/rcb_column.sv
module rcb_column #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  // Nonblocking update: a read at the written address sees the old word.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we) mem_q[waddr] <= wdata;
      rdata_q <= mem_q[raddr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/rcb_bank.sv
module rcb_bank
  import rcb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_pat,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [NUM_COL*ADDR_W-1:0]   rd_addr,
  output logic [NUM_COL*DATA_W-1:0]   rd_data
);
  // Per-column write enables, brought out for the checker.
  logic [NUM_COL-1:0] col_we;

  rcb_pat_dec u_dec (
    .wr_en  (wr_en),
    .wr_pat (wr_pat),
    .col_we (col_we)
  );

  for (genvar g = 0; g < NUM_COL; g++) begin : g_col
    rcb_column #(.DW(DATA_W), .AW(ADDR_W)) u_col (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (col_we[g]),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr[g*ADDR_W +: ADDR_W]),
      .rdata (rd_data[g*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/rcb_bank_chk.sv
module rcb_bank_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_pat,
  input logic [4*AW-1:0] rd_addr,
  input logic [4*DW-1:0] rd_data,
  input logic [3:0]    col_we
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0)); // R1

  AST_PAT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pat == 2'b00) |-> (col_we == 4'b1111)); // R2

  AST_PAT_C12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pat == 2'b01) |-> (col_we == 4'b0011)); // R3

  AST_PAT_C13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pat == 2'b10) |-> (col_we == 4'b0101)); // R4

  AST_PAT_C1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pat == 2'b11) |-> ($countones(col_we) == 1 && col_we[0])); // R5

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (col_we == 4'b0000)); // R6

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(rd_addr)) |=> $stable(rd_data)); // R7
endmodule

bind rcb_bank rcb_bank_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_pat  (wr_pat),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .col_we  (col_we)
);

// File: tb/rcb_bank_bench.sv
`timescale 1ns/1ps
module rcb_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_pat;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] rd_addr;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [4][16];

  always #2.5 clk = ~clk;

  rcb_bank u_rcb_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pat(wr_pat),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Vector: {expected column mask[3:0], we, pattern[1:0], addr[3:0], data[7:0]}
  localparam logic [18:0] VEC [12] = '{
    {4'b1111, 1'b1, 2'b00, 4'h0, 8'h11},
    {4'b0011, 1'b1, 2'b01, 4'h0, 8'h22},
    {4'b0101, 1'b1, 2'b10, 4'h0, 8'h33},
    {4'b0001, 1'b1, 2'b11, 4'h0, 8'h44},
    {4'b0000, 1'b0, 2'b00, 4'h0, 8'hEE},
    {4'b1111, 1'b1, 2'b00, 4'hF, 8'hA5},
    {4'b0000, 1'b0, 2'b11, 4'hF, 8'h5A},
    {4'b0011, 1'b1, 2'b01, 4'hF, 8'h0F},
    {4'b0101, 1'b1, 2'b10, 4'h7, 8'hC3},
    {4'b0001, 1'b1, 2'b11, 4'h7, 8'h3C},
    {4'b1111, 1'b1, 2'b00, 4'h8, 8'hFF},
    {4'b0000, 1'b0, 2'b01, 4'h8, 8'h00}
  };

  function automatic logic [3:0] ref_mask(input logic we, input logic [1:0] p);
    if (!we) return 4'b0000;
    if (p == 2'b00) return 4'b1111;
    if (p == 2'b01) return 4'b0011;
    if (p == 2'b10) return 4'b0101;
    return 4'b0001;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 16; a++) model[c][a] = 8'h00;
  endtask

  // One cycle: drive, take an edge, check each lane against the pre-write model.
  task automatic step(input string req, input logic we, input logic [1:0] p,
                      input logic [3:0] wa, input logic [7:0] wd, input logic [15:0] ra,
                      input logic [3:0] m);
    logic [7:0] exp [4];
    wr_en = we; wr_pat = p; wr_addr = wa; wr_data = wd; rd_addr = ra;
    for (int k = 0; k < 4; k++) exp[k] = model[k][ra[4*k +: 4]];
    for (int k = 0; k < 4; k++) if (m[k]) model[k][wa] = wd;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) check(req, rd_data[8*k +: 8], exp[k]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_pat = 2'b00; wr_addr = '0; wr_data = '0; rd_addr = '0;
    @(negedge clk);
    do_reset();
    // R1: reset state of all lanes
    for (int k = 0; k < 4; k++) check("R1 reset lanes", rd_data[8*k +: 8], 8'h00);

    // Table walk: R2 R3 R4 R5 R6 masks, then read the written address back.
    for (int i = 0; i < 12; i++) begin
      logic [18:0] v;
      v = VEC[i];
      step("R2-R6 table write", v[14], v[13:12], v[11:8], v[7:0], {4{v[11:8]}}, v[18:15]);
      step("R7 table readback", 1'b0, 2'b00, 4'h0, 8'h00, {4{v[11:8]}}, 4'b0000);
    end

    // R10: successive codes on one address
    step("R10", 1'b1, 2'b00, 4'h5, 8'hD4, 16'h0, 4'b1111);
    step("R10", 1'b1, 2'b01, 4'h5, 8'hD3, 16'h0, 4'b0011);
    step("R10", 1'b1, 2'b10, 4'h5, 8'hD2, 16'h0, 4'b0101);
    step("R10", 1'b1, 2'b11, 4'h5, 8'hD1, 16'h0, 4'b0001);
    wr_en = 1'b0; rd_addr = 16'h5555;
    @(posedge clk); @(negedge clk);
    check("R10 col1", rd_data[7:0],   8'hD1);
    check("R10 col2", rd_data[15:8],  8'hD3);
    check("R10 col3", rd_data[23:16], 8'hD2);
    check("R10 col4", rd_data[31:24], 8'hD4);

    // R9: same-cycle read and write returns old byte, new one next edge
    step("R9 old", 1'b1, 2'b00, 4'h5, 8'h99, 16'h5555, 4'b1111);
    step("R9 new", 1'b0, 2'b00, 4'h0, 8'h00, 16'h5555, 4'b0000);
    wr_en = 1'b0;
    for (int k = 0; k < 4; k++) check("R9 new visible", rd_data[8*k +: 8], 8'h99);

    // R8: four different addresses at once
    step("R8 distinct", 1'b0, 2'b00, 4'h0, 8'h00, 16'h7F05, 4'b0000);
    step("R8 distinct", 1'b0, 2'b00, 4'h0, 8'h00, 16'h058F, 4'b0000);

    // Random run against the reference model (R2 to R9).
    for (int n = 0; n < 3000; n++) begin
      logic we;
      logic [1:0] p;
      we = ($urandom_range(0, 3) != 0);
      p = 2'($urandom_range(0, 3));
      step("R2-R9 random", we, p, 4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)),
           16'($urandom_range(0, 65535)), ref_mask(we, p));
    end

    // R1: reset mid-run clears stored bytes
    do_reset();
    for (int a = 0; a < 16; a++)
      step("R1 cleared", 1'b0, 2'b00, 4'h0, 8'h00, {4{4'(a)}}, 4'b0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule